// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable single-port synchronous SRAM whose data phase always trails its command by exactly one clock. Reads are flow-through: the array output reaches the data pins combinationally from the registered address, with no output register. Writes take their data on the clock edge that follows the command. Because both operation kinds share the same one-cycle offset, reads and writes can be interleaved on consecutive cycles without any idle cycle on the shared data bus.

A command starts when the load strobe is low and all three chip selects are active. With the load strobe high, the block continues the current burst. It steps the two low address bits through four beats in linear or XOR order, and it keeps the direction of the command that loaded the burst. An active-low clock enable freezes the whole block. The asynchronous output enable can silence the pins at any moment. The bidirectional data bus is split into an input, an output and a drive-enable, so that the pad logic outside the block can rebuild it.

Top module: `zsram_zbt`

## Requirements
- R1: A read command sampled on edge k drives `dq_oe`=1 and `dq_out` = the word at the command address during the cycle after edge k, with no extra latency.
- R2: A write command sampled on edge k stores `dq_in` at edge k+1 into the captured address. Bit i of `be_n` (active low, sampled with the command) gates lane i, which is bits 9i+8..9i; lanes with `be_n[i]`=1 keep their old content.
- R3: Reads and writes can follow each other on every cycle in any mix; each operation keeps its one-cycle data offset.
- R4: While `cke_n`=1, all synchronous inputs are ignored: nothing is written, no command is captured, and the bus keeps showing the phase it showed before.
- R5: A new operation starts only when `adv_load`=0, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load cycle with any select inactive issues nothing, drives `dq_oe`=0 in the following cycle and ends the burst, so a later advance also issues nothing.
- R6: An operation captured before a deselect still completes: a pending write is stored and a pending read is driven.
- R7: `dq_oe` is 0 during the data cycle of a write.
- R8: `oe_n`=1 forces `dq_oe` to 0 immediately, independent of the clock.
- R9: With `adv_load`=1 after a load, the next beat uses the burst address. The upper bits stay fixed. The low two bits are base+n mod 4 if `order_lin` was 1 at the load, and base XOR n if it was 0, for beat n=1,2,3,0,… The direction of the load is kept.
- R10: A read issued in the cycle right after a write to the same address returns the newly written data.
- R11: After the synchronous active-low reset, no operation is pending, `dq_oe` is 0, and an advance cycle issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; 1 freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv_load | input | 1 | 0 loads a new address, 1 advances the burst |
| rd_wr | input | 1 | 1 read, 0 write (sampled on load) |
| order_lin | input | 1 | Burst order: 1 linear, 0 XOR |
| be_n | input | 4 | Lane write enables, active low |
| addr | input | 8 | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data, sampled one edge after the command |
| dq_out | output | 36 | Read data, flow-through |
| dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The hardest situations to reach are the overlaps. In one, the clock enable freezes a half-finished operation. In the other, a deselect arrives while a write is still waiting for its data. In both, the pin values at one edge belong to two different operations. The bench runs a reference model, steps it once for each driven cycle, and queues the expected bus state. Directed sequences place a stall in the middle of a write, a deselect right after a write, and a read right behind a write to the same word. A long random phase then mixes stalls, partial deselects, bursts in both orders and lane masks over a fully preloaded array.

// File: rtl/zsram_pkg.sv
// Shared types for the zero-turnaround SRAM.
// Assumes nothing beyond the enum encodings below.
package zsram_pkg;
    // Burst ordering captured at a load (encoding matches the order_lin pin)
    typedef enum logic {
        ORDER_XOR    = 1'b0,
        ORDER_LINEAR = 1'b1
    } burst_order_e;
endpackage

// File: rtl/zsram_burst.sv
// Burst address generator: holds the loaded base address and a beat counter.
// It yields the address that the control stage captures on this edge.
// Assumes BB >= 1 and that the caller raises at most one of load/advance/kill.
module zsram_burst
    import zsram_pkg::*;
#(
    parameter int AW = 8,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          load,
    input  logic          advance,
    input  logic          kill,
    input  logic          order_lin,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] cur_addr,
    output logic          live
);
    localparam int HB = AW - BB;

    logic [AW-1:0] base_q;
    logic [BB-1:0] cnt_q;
    burst_order_e  order_q;
    logic          live_q;
    logic [BB-1:0] cnt_nx;
    logic [BB-1:0] low_nx;

    // Next beat index and its low address bits in the captured order
    always_comb begin
        cnt_nx = cnt_q + 1'b1;
        if (order_q == ORDER_LINEAR)
            low_nx = base_q[BB-1:0] + cnt_nx;
        else
            low_nx = base_q[BB-1:0] ^ cnt_nx;
    end

    // Address offered to the capture stage: external on load, burst otherwise
    always_comb begin
        if (load)
            cur_addr = ext_addr;
        else
            cur_addr = {base_q[AW-1:BB], low_nx};
    end

    assign live = live_q;

    // Burst state update, frozen when the clock enable is inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            cnt_q   <= '0;
            order_q <= ORDER_XOR;
            live_q  <= 1'b0;
        end else if (step_en) begin
            if (load) begin
                base_q  <= ext_addr;
                cnt_q   <= '0;
                order_q <= burst_order_e'(order_lin);
                live_q  <= 1'b1;
            end else if (advance) begin
                cnt_q <= cnt_nx;
            end else if (kill) begin
                live_q <= 1'b0;
            end
        end
    end

    // R9
    burst_base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && advance) |=> (base_q == $past(base_q)));

    // R5
    burst_end_on_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && kill) |=> !live);

    logic unused_hb;
    assign unused_hb = (HB < 0);
endmodule

// File: rtl/zsram_ctrl.sv
// Command stage: decodes load/advance/deselect and registers the pending operation.
// That operation's data phase occupies the next cycle. Assumes the burst generator
// supplies the capture address for both loads and advances.
module zsram_ctrl #(
    parameter int AW = 8,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n,
    input  logic          adv_load,
    input  logic          sel_ok,
    input  logic          rd_wr,
    input  logic [NB-1:0] be_n,
    input  logic          burst_live,
    input  logic [AW-1:0] burst_addr,
    output logic          load,
    output logic          advance,
    output logic          kill,
    output logic          acc_write,
    output logic          pend_valid,
    output logic          pend_rd,
    output logic [AW-1:0] pend_addr,
    output logic [NB-1:0] pend_be_n
);
    logic          dir_q;
    logic          op_rd;
    logic          issue;
    logic          pv_q;
    logic          prd_q;
    logic [AW-1:0] pa_q;
    logic [NB-1:0] pbe_q;

    // Command decode from the strobe and the three selects
    always_comb begin
        load      = !adv_load && sel_ok;
        kill      = !adv_load && !sel_ok;
        advance   = adv_load && burst_live;
        issue     = load || advance;
        op_rd     = load ? rd_wr : dir_q;
        acc_write = issue && !op_rd;
    end

    // Pending operation register, held while the clock enable is inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q  <= 1'b0;
            prd_q <= 1'b0;
            pa_q  <= '0;
            pbe_q <= '1;
        end else if (!cke_n) begin
            pv_q  <= issue;
            prd_q <= op_rd;
            pa_q  <= burst_addr;
            pbe_q <= be_n;
        end
    end

    // Burst direction remembered from the last load
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= 1'b1;
        else if (!cke_n && load)
            dir_q <= rd_wr;
    end

    assign pend_valid = pv_q;
    assign pend_rd    = prd_q;
    assign pend_addr  = pa_q;
    assign pend_be_n  = pbe_q;

    // R4
    hold_freezes_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable({pv_q, prd_q, pa_q, pbe_q, dir_q}));

    // R9
    advance_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && advance) |=> (pend_rd == $past(dir_q)));
endmodule

// File: rtl/zsram_array.sv
// Storage: one word array per 9-bit lane, with a synchronous lane-masked write and
// a combinational (flow-through) read. Assumes we is already qualified by the clock enable.
module zsram_array #(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [NB-1:0]    wbe,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*LW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Lane write on the data edge when this lane is enabled
        always_ff @(posedge clk) begin
            if (we && wbe[g])
                mem[waddr] <= wdata[g*LW +: LW];
        end

        assign rdata[g*LW +: LW] = mem[raddr];
    end
endmodule

// File: rtl/zsram_zbt.sv
// Top of the zero-turnaround SRAM: ties the command stage, the burst generator
// and the lane array together and forms the pad drive enable.
// Assumes the outer pad logic merges dq_out/dq_in/dq_oe into one bus.
module zsram_zbt #(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             adv_load,
    input  logic             rd_wr,
    input  logic             order_lin,
    input  logic [NB-1:0]    be_n,
    input  logic [AW-1:0]    addr,
    input  logic             oe_n,
    input  logic [NB*LW-1:0] dq_in,
    output logic [NB*LW-1:0] dq_out,
    output logic             dq_oe
);
    localparam int DW = NB * LW;
    localparam int BB = 2;

    logic          sel_ok;
    logic          load;
    logic          advance;
    logic          kill;
    logic          acc_write;
    logic          burst_live;
    logic [AW-1:0] burst_addr;
    logic          pend_valid;
    logic          pend_rd;
    logic [AW-1:0] pend_addr;
    logic [NB-1:0] pend_be_n;
    logic          arr_we;
    logic [DW-1:0] arr_rdata;

    // All three selects must be active for a new command
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    zsram_ctrl #(.AW(AW), .NB(NB)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_n      (cke_n),
        .adv_load   (adv_load),
        .sel_ok     (sel_ok),
        .rd_wr      (rd_wr),
        .be_n       (be_n),
        .burst_live (burst_live),
        .burst_addr (burst_addr),
        .load       (load),
        .advance    (advance),
        .kill       (kill),
        .acc_write  (acc_write),
        .pend_valid (pend_valid),
        .pend_rd    (pend_rd),
        .pend_addr  (pend_addr),
        .pend_be_n  (pend_be_n)
    );

    zsram_burst #(.AW(AW), .BB(BB)) i_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (!cke_n),
        .load      (load),
        .advance   (advance),
        .kill      (kill),
        .order_lin (order_lin),
        .ext_addr  (addr),
        .cur_addr  (burst_addr),
        .live      (burst_live)
    );

    // Data-edge write of the pending operation
    assign arr_we = !cke_n && pend_valid && !pend_rd;

    zsram_array #(.AW(AW), .NB(NB), .LW(LW)) i_array (
        .clk   (clk),
        .we    (arr_we),
        .wbe   (~pend_be_n),
        .waddr (pend_addr),
        .wdata (dq_in),
        .raddr (pend_addr),
        .rdata (arr_rdata)
    );

    // Flow-through read path and asynchronous pad enable
    always_comb begin
        dq_out = arr_rdata;
        dq_oe  = pend_valid && pend_rd && !oe_n;
    end

    // R8
    oe_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !oe_n);

    // R7
    write_phase_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && acc_write) |=> !dq_oe);

    // R5
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_load && !sel_ok) |=> !dq_oe);

    // R9
    burst_upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_load && burst_live) |=> (pend_addr[AW-1:BB] == $past(pend_addr[AW-1:BB])));
endmodule

// File: tb/test_zsram_zbt.sv
// Scoreboard bench: the driver steps a reference model once per cycle and queues the
// expected bus state; the monitor pops one entry per cycle and compares it.
module test_zsram_zbt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_n = 1'b0;
    logic        sel_a_n = 1'b1;
    logic        sel_b = 1'b0;
    logic        sel_c_n = 1'b1;
    logic        adv_load = 1'b0;
    logic        rd_wr = 1'b1;
    logic        order_lin = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic [7:0]  addr = '0;
    logic        oe_n = 1'b0;
    logic [35:0] dq_in = '0;
    logic [35:0] dq_out;
    logic        dq_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    zsram_zbt i_zsram_zbt (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .adv_load(adv_load), .rd_wr(rd_wr), .order_lin(order_lin),
        .be_n(be_n), .addr(addr), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // reference model state
    logic [35:0] m_mem [256];
    bit          m_valid = 0;
    bit          m_rd = 0;
    logic [7:0]  m_addr = '0;
    logic [3:0]  m_be = 4'hF;
    bit          m_live = 0;
    logic [7:0]  m_base = '0;
    logic [1:0]  m_cnt = '0;
    bit          m_lin = 0;
    bit          m_dir = 1;

    bit          eq_oe[$];
    logic [35:0] eq_d[$];
    string       eq_tag[$];

    task automatic check(input string tag, input bit ok, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle; sel bits: [0]=sel_a active, [1]=sel_b active, [2]=sel_c active
    task automatic step(input string tag, input bit ck, input bit adv, input logic [2:0] s,
                        input bit rd, input bit ord, input logic [7:0] a,
                        input logic [3:0] be, input logic [35:0] wd);
        @(negedge clk);
        cke_n = ck; adv_load = adv; sel_a_n = !s[0]; sel_b = s[1]; sel_c_n = !s[2];
        rd_wr = rd; order_lin = ord; addr = a; be_n = be; dq_in = wd;
        if (!ck) begin
            if (m_valid && !m_rd)
                for (int i = 0; i < 4; i++)
                    if (!m_be[i]) m_mem[m_addr][i*9 +: 9] = wd[i*9 +: 9];
            if (!adv && (&s)) begin
                m_live = 1; m_base = a; m_cnt = 0; m_lin = ord; m_dir = rd;
                m_valid = 1; m_rd = rd; m_addr = a;
            end else if (!adv) begin
                m_live = 0; m_valid = 0;
            end else if (m_live) begin
                m_cnt = m_cnt + 2'd1;
                m_valid = 1; m_rd = m_dir;
                m_addr = {m_base[7:2], m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
            end else begin
                m_valid = 0;
            end
            m_be = be;
        end
        eq_oe.push_back(m_valid && m_rd);
        eq_d.push_back(m_mem[m_addr]);
        eq_tag.push_back(tag);
    endtask

    // shorthands
    task automatic ld(input string tag, input bit rd, input logic [7:0] a, input logic [35:0] wd);
        step(tag, 0, 0, 3'b111, rd, 1, a, 4'h0, wd);
    endtask
    task automatic idle(input string tag, input logic [35:0] wd);
        step(tag, 0, 0, 3'b000, 1, 1, 8'h00, 4'h0, wd);
    endtask

    // monitor: compare the data phase shortly after each edge
    always @(posedge clk) begin
        #4;
        if (eq_oe.size() > 0) begin
            bit          e_oe;
            logic [35:0] e_d;
            string       t;
            e_oe = eq_oe.pop_front();
            e_d  = eq_d.pop_front();
            t    = eq_tag.pop_front();
            if (dq_oe !== e_oe)
                check({t, " dq_oe"}, 0, {35'd0, dq_oe}, {35'd0, e_oe});
            else if (e_oe)
                check({t, " dq_out"}, dq_out === e_d, dq_out, e_d);
            else
                check({t, " hiz"}, 1, 36'd0, 36'd0);
        end
    end

    // watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset dq_oe", dq_oe === 1'b0, {35'd0, dq_oe}, 36'd0);
        rst_n = 1'b1;
        // R11: advance right after reset issues nothing
        step("R11", 0, 1, 3'b111, 1, 1, 8'h00, 4'h0, '0);
        step("R11", 0, 1, 3'b111, 1, 1, 8'h00, 4'h0, '0);

        // preload every word (R3 back-to-back writes)
        for (int i = 0; i < 256; i++)
            ld("R2 preload", 0, 8'(i), {4'(i), 32'(i * 32'h01010101) ^ 32'h5A5A0000});
        idle("R7", 36'h0_DEAD_BEEF ^ 36'd255);

        // R9 linear write burst from 0x21: 21,22,23,20
        step("R9", 0, 0, 3'b111, 0, 1, 8'h21, 4'h0, '0);
        step("R9", 0, 1, 3'b111, 1, 0, 8'hFF, 4'h0, 36'h1_1111_0021);
        step("R9", 0, 1, 3'b111, 1, 0, 8'hFF, 4'h0, 36'h1_1111_0022);
        step("R9", 0, 1, 3'b111, 1, 0, 8'hFF, 4'h0, 36'h1_1111_0023);
        // R9 XOR read burst from 0x46 right behind the writes (R3): 46,47,44,45
        step("R9 R3", 0, 0, 3'b111, 1, 0, 8'h46, 4'h0, 36'h1_1111_0020);
        step("R9", 0, 1, 3'b111, 0, 1, 8'h00, 4'h0, '0);
        step("R9", 0, 1, 3'b111, 0, 1, 8'h00, 4'h0, '0);
        step("R9", 0, 1, 3'b111, 0, 1, 8'h00, 4'h0, '0);
        step("R9 wrap", 0, 1, 3'b111, 0, 1, 8'h00, 4'h0, '0);
        // R1 read linear burst back
        ld("R1", 1, 8'h21, '0);
        step("R1 R9", 0, 1, 3'b111, 0, 0, 8'h00, 4'h0, '0);
        step("R1 R9", 0, 1, 3'b111, 0, 0, 8'h00, 4'h0, '0);
        step("R1 R9", 0, 1, 3'b111, 0, 0, 8'h00, 4'h0, '0);

        // R2 lane-masked write: lanes 0 and 2 only
        step("R2", 0, 0, 3'b111, 0, 1, 8'h05, 4'b1010, '0);
        ld("R2 R3", 1, 8'h05, 36'hF_FFFF_FFFF);
        // R10 write then read same word next cycle
        ld("R10", 0, 8'h30, '0);
        ld("R10", 1, 8'h30, 36'h9_8765_4321);
        ld("R3", 0, 8'h31, '0);
        ld("R3", 1, 8'h30, 36'h0_ABCD_0031);

        // R4 stall in the middle of a write: junk data ignored while held
        ld("R4", 0, 8'h40, '0);
        step("R4", 1, 0, 3'b111, 1, 1, 8'h41, 4'h0, 36'hE_EEEE_EEEE);
        step("R4", 1, 0, 3'b111, 0, 1, 8'h42, 4'h0, 36'hD_DDDD_DDDD);
        ld("R4", 1, 8'h40, 36'h4_4444_0040);
        // R4 stall during a read: data stays on the bus
        step("R4", 1, 0, 3'b111, 0, 1, 8'h43, 4'h0, 36'h7_7777_7777);
        step("R4", 1, 1, 3'b000, 0, 1, 8'h44, 4'h0, 36'h7_7777_7777);
        ld("R4", 1, 8'h41, '0);

        // R6 write pending across a deselect, then R5 advance does nothing
        ld("R6", 0, 8'h50, '0);
        step("R6 R5", 0, 0, 3'b101, 0, 1, 8'h51, 4'h0, 36'h5_0505_0050);
        step("R5", 0, 1, 3'b111, 0, 1, 8'h52, 4'h0, 36'h6_6666_6666);
        ld("R6", 1, 8'h50, '0);
        // R6 read pending across a deselect still drives data
        step("R6 R5", 0, 0, 3'b110, 1, 1, 8'h53, 4'h0, '0);
        step("R5", 0, 0, 3'b011, 0, 1, 8'h54, 4'h0, '0);

        // R8 asynchronous output enable
        ld("R8", 1, 8'h22, '0);
        @(posedge clk);
        #8;
        oe_n = 1'b1;
        #1;
        check("R8 oe_n forces hiz", dq_oe === 1'b0, {35'd0, dq_oe}, 36'd0);
        oe_n = 1'b0;
        #0;
        check("R8 oe_n release", dq_oe === 1'b1, {35'd0, dq_oe}, 36'd1);

        // R3 random mix of everything
        for (int k = 0; k < 600; k++) begin
            logic [2:0] s;
            s = ($urandom % 6 == 0) ? 3'($urandom) : 3'b111;
            step("R3 random", ($urandom % 7) == 0, ($urandom % 3) == 0, s,
                 1'($urandom), 1'($urandom), 8'($urandom), 4'($urandom),
                 {4'($urandom), 32'($urandom)});
        end
        idle("R3 flush", 36'h0);
        idle("R3 flush", 36'h0);
        while (eq_oe.size() > 0) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule